// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Write Slave

This block is the target side of a two-wire serial memory. It samples the clock and data lines on its system clock and finds bus start and stop events. It compares the first byte of each transfer with its device address. When that byte is a write request for this device, it takes a word address and then one or more data bytes. These bytes are collected in a page buffer, and a register memory array receives them when a timed write cycle ends. The data line is open-drain. The block only asserts an output enable, which pulls the wire low.

After a stop that ends a transfer carrying data, the block holds a busy state for a fixed number of system clocks. In that state it ignores the bus completely. It acknowledges nothing and reacts to no start or stop. A master can therefore poll with repeated write-address bytes until one is acknowledged. A debug read port returns any memory byte combinationally, so that contents can be checked without bus reads.

The controller has these states: `ST_IDLE`, `ST_DEV_ADDR`, `ST_DEV_ACK`, `ST_WORD_ADDR`, `ST_WORD_ACK`, `ST_DATA`, `ST_DATA_ACK`, `ST_IGNORE` and `ST_WRITE_CYCLE`. A start moves any state except `ST_WRITE_CYCLE` to `ST_DEV_ADDR`. A stop moves any state except `ST_WRITE_CYCLE` to `ST_WRITE_CYCLE` when buffered bytes exist, and to `ST_IDLE` otherwise. The eighth SCL fall of a byte moves each byte state to its acknowledge state. For the address byte, a mismatch moves to `ST_IGNORE` instead. The SCL fall that ends the ninth bit moves each acknowledge state to the following byte state. `ST_WRITE_CYCLE` returns to `ST_IDLE` when its timer expires.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset, `sda_oe_o` and `busy_o` are 0 and every memory byte reads 8'hFF.
- R2: The block drives the acknowledge for a first byte of 1010, then `dev_sel_i` (MSB first), then a 0 direction bit in its LSB. The output enable rises after the SCL fall that ends bit 8 and stays high through the ninth SCL high phase. It is released after the next SCL fall.
- R3: A first byte whose upper nibble is not 1010, or whose bits 3..1 differ from `dev_sel_i`, is not acknowledged. Nothing else is acknowledged or stored until the next start.
- R4: A matching first byte whose direction bit (bit 0) is 1 is not acknowledged and the transfer is ignored.
- R5: In an acknowledged write, the word address byte and every data byte are acknowledged.
- R6: One data byte followed by a stop stores that byte at the word address.
- R7: Successive data bytes go to successive addresses. Only the low 4 address bits advance, so a page of 16 bytes wraps onto itself and the upper address bits never change.
- R8: When more than 16 data bytes arrive, a later byte that lands on a location already written replaces the earlier one.
- R9: A stop after at least one data byte makes `busy_o` high for exactly `WR_CYCLES` system clocks. Memory keeps its old contents during that time and holds the new bytes once `busy_o` falls.
- R10: While `busy_o` is high, no byte is acknowledged, no byte is stored, and start and stop events neither restart nor end the timer.
- R11: A stop that arrives before any data byte starts no write cycle.
- R12: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A repeated start inside a write discards the bytes that this write buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| dev_sel_i | input | 3 | Device select bits compared with address bits 3..1 |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls the data wire low |
| busy_o | output | 1 | High during the timed write cycle |
| dbg_addr_i | input | ADDR_W | Debug read address |
| dbg_data_o | output | 8 | Memory byte at the debug address |

## Verification
The write path is driven with transfers of different lengths. A single byte shows that the base address is used. A mid-page run checks that addresses advance. A run that starts near the page end shows that only the low address bits wrap, a full 16-byte page fills every lane, and a 19-byte run shows the last-writer-wins overwrite. Three kinds of first byte are compared with the matching one: a wrong select, a wrong device type and a read request. This shows that each field of the address comparison matters. Polling during the busy window shows that the bus is ignored and the timer runs on unchanged. A repeated start and an address-only transfer show that no write cycle starts without buffered data.

// File: rtl/eeprom_slave_pkg.sv
`timescale 1ns/1ps
package eeprom_slave_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV_ADDR,
        ST_DEV_ACK,
        ST_WORD_ADDR,
        ST_WORD_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE,
        ST_WRITE_CYCLE
    } slave_state_t;

endpackage

// File: rtl/bus_line_sync.sv
`timescale 1ns/1ps
module bus_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;
    logic scl_now, scl_prev, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
        end
    end

    assign scl_now  = scl_pipe[SYNC_STAGES-1];
    assign scl_prev = scl_pipe[SYNC_STAGES];
    assign sda_s    = sda_pipe[SYNC_STAGES-1];
    assign sda_prev = sda_pipe[SYNC_STAGES];

    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign start_det = scl_now & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/page_collect.sv
`timescale 1ns/1ps
module page_collect #(
    parameter int PAGE_BYTES = 16,
    localparam int LANE_W = $clog2(PAGE_BYTES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      wr_en,
    input  logic [LANE_W-1:0]         wr_lane,
    input  logic [7:0]                wr_data,
    output logic [PAGE_BYTES*8-1:0]   lane_data,
    output logic [PAGE_BYTES-1:0]     lane_valid,
    output logic                      any_valid
);
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_data[g*8 +: 8] <= '0;
                lane_valid[g]       <= 1'b0;
            end else if (clear) begin
                lane_valid[g]       <= 1'b0;
            end else if (wr_en && (wr_lane == LANE_W'(g))) begin
                lane_data[g*8 +: 8] <= wr_data;
                lane_valid[g]       <= 1'b1;
            end
        end
    end

    assign any_valid = |lane_valid;

endmodule

// File: rtl/byte_store.sv
`timescale 1ns/1ps
module byte_store #(
    parameter int DEPTH      = 256,
    parameter int PAGE_BYTES = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LANE_W = $clog2(PAGE_BYTES),
    localparam int PAGE_W = ADDR_W - LANE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     page_we,
    input  logic [PAGE_W-1:0]        page_sel,
    input  logic [PAGE_BYTES*8-1:0]  lane_data,
    input  logic [PAGE_BYTES-1:0]    lane_mask,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) cells[a] <= 8'hFF;
        end else if (page_we) begin
            for (int l = 0; l < PAGE_BYTES; l++) begin
                if (lane_mask[l]) cells[{page_sel, LANE_W'(l)}] <= lane_data[l*8 +: 8];
            end
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/serial_eeprom_slave.sv
`timescale 1ns/1ps
module serial_eeprom_slave
    import eeprom_slave_pkg::*;
#(
    parameter int DEPTH       = 256,
    parameter int PAGE_BYTES  = 16,
    parameter int WR_CYCLES   = 1000,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LANE_W = $clog2(PAGE_BYTES),
    localparam int PAGE_W = ADDR_W - LANE_W,
    localparam int TMR_W  = $clog2(WR_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        dev_sel_i,
    output logic              sda_oe_o,
    output logic              busy_o,
    input  logic [ADDR_W-1:0] dbg_addr_i,
    output logic [7:0]        dbg_data_o
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    slave_state_t state, nxt;
    logic [3:0]        bit_cnt;
    logic [7:0]        shreg;
    logic              ack_hi;
    logic [ADDR_W-1:0] word_addr;
    logic [TMR_W-1:0]  timer;

    logic byte_done, ack_done, addr_ok, timer_last, mem_we;
    logic in_byte, in_ack, buf_wr, buf_clear;
    logic [PAGE_BYTES*8-1:0] lane_data;
    logic [PAGE_BYTES-1:0]   lane_valid;
    logic                    pending;

    bus_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign in_byte    = (state == ST_DEV_ADDR) || (state == ST_WORD_ADDR) || (state == ST_DATA);
    assign in_ack     = (state == ST_DEV_ACK) || (state == ST_WORD_ACK) || (state == ST_DATA_ACK);
    assign byte_done  = in_byte && scl_fall && (bit_cnt == 4'd8);
    assign ack_done   = in_ack && scl_fall && ack_hi;
    assign addr_ok    = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == dev_sel_i) && !shreg[0];
    assign timer_last = (timer == TMR_W'(WR_CYCLES - 1));

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:        nxt = ST_IDLE;
            ST_DEV_ADDR:    if (byte_done) nxt = addr_ok ? ST_DEV_ACK : ST_IGNORE;
            ST_DEV_ACK:     if (ack_done) nxt = ST_WORD_ADDR;
            ST_WORD_ADDR:   if (byte_done) nxt = ST_WORD_ACK;
            ST_WORD_ACK:    if (ack_done) nxt = ST_DATA;
            ST_DATA:        if (byte_done) nxt = ST_DATA_ACK;
            ST_DATA_ACK:    if (ack_done) nxt = ST_DATA;
            ST_IGNORE:      nxt = ST_IGNORE;
            ST_WRITE_CYCLE: if (timer_last) nxt = ST_IDLE;
            default:        nxt = ST_IDLE;
        endcase
        if (state != ST_WRITE_CYCLE) begin
            if (start_det)     nxt = ST_DEV_ADDR;
            else if (stop_det) nxt = pending ? ST_WRITE_CYCLE : ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // byte framing, word address and write timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            ack_hi    <= 1'b0;
            word_addr <= '0;
            timer     <= '0;
        end else begin
            if (state == ST_WRITE_CYCLE) timer <= timer + 1'b1;
            else                         timer <= '0;

            if (state != ST_WRITE_CYCLE && start_det) begin
                bit_cnt <= '0;
                ack_hi  <= 1'b0;
            end else if (in_byte) begin
                if (scl_rise && bit_cnt != 4'd8) begin
                    shreg   <= {shreg[6:0], sda_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (byte_done && state == ST_WORD_ADDR) word_addr <= shreg[ADDR_W-1:0];
                if (byte_done && state == ST_DATA)
                    word_addr[LANE_W-1:0] <= word_addr[LANE_W-1:0] + 1'b1;
            end else if (in_ack) begin
                if (scl_rise) ack_hi <= 1'b1;
                if (ack_done) begin
                    ack_hi  <= 1'b0;
                    bit_cnt <= '0;
                end
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe_o = in_ack;
        busy_o   = (state == ST_WRITE_CYCLE);
        mem_we   = (state == ST_WRITE_CYCLE) && timer_last;
    end

    assign buf_wr    = byte_done && (state == ST_DATA);
    assign buf_clear = ((state != ST_WRITE_CYCLE) && start_det) || mem_we;

    page_collect #(.PAGE_BYTES(PAGE_BYTES)) i_page (
        .clk(clk), .rst_n(rst_n), .clear(buf_clear), .wr_en(buf_wr),
        .wr_lane(word_addr[LANE_W-1:0]), .wr_data(shreg),
        .lane_data(lane_data), .lane_valid(lane_valid), .any_valid(pending)
    );

    byte_store #(.DEPTH(DEPTH), .PAGE_BYTES(PAGE_BYTES)) i_store (
        .clk(clk), .rst_n(rst_n), .page_we(mem_we),
        .page_sel(word_addr[ADDR_W-1:LANE_W]),
        .lane_data(lane_data), .lane_mask(lane_valid),
        .rd_addr(dbg_addr_i), .rd_data(dbg_data_o)
    );

endmodule

// File: rtl/eeprom_slave_chk.sv
`timescale 1ns/1ps
module eeprom_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_oe_o,
    input logic busy_o,
    input logic start_det,
    input logic stop_det,
    input logic scl_fall,
    input logic mem_we
);
    // R10
    quiet_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !sda_oe_o);

    // R9
    busy_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_det));

    // R9
    commit_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(mem_we));

    // R9
    commit_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy_o);

    // R2
    ack_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> $past(scl_fall));

    // R2
    ack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe_o) |-> $past(scl_fall || start_det || stop_det));

endmodule

bind serial_eeprom_slave eeprom_slave_chk i_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe_o(sda_oe_o), .busy_o(busy_o),
    .start_det(start_det), .stop_det(stop_det), .scl_fall(scl_fall),
    .mem_we(mem_we)
);

// File: tb/test_serial_eeprom_slave.sv
`timescale 1ns/1ps
module test_serial_eeprom_slave;
    localparam int WR_CYC = 1000;
    localparam int H      = 10;
    localparam int NVEC   = 9;
    localparam logic [2:0] SEL = 3'b101;

    // {device byte, word address, data count, first data value, expected ack}
    localparam logic [29:0] VEC [NVEC] = '{
        {8'hAA, 8'h10, 5'd1,  8'h3C, 1'b1},
        {8'hAA, 8'h24, 5'd4,  8'h50, 1'b1},
        {8'hAA, 8'h3D, 5'd6,  8'h70, 1'b1},
        {8'hAA, 8'h40, 5'd16, 8'h80, 1'b1},
        {8'hAA, 8'h5E, 5'd19, 8'hA0, 1'b1},
        {8'hA8, 8'h60, 5'd2,  8'h11, 1'b0},
        {8'h2A, 8'h62, 5'd2,  8'h22, 1'b0},
        {8'hAB, 8'h64, 5'd2,  8'h33, 1'b0},
        {8'hAA, 8'h70, 5'd0,  8'h44, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe, busy;
    logic [7:0] dbg_addr = '0;
    logic [7:0] dbg_data;
    logic [7:0] model [256];
    int n_chk = 0;
    int n_fail = 0;
    int busy_run = 0;
    int last_len = 0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    serial_eeprom_slave #(.WR_CYCLES(WR_CYC)) i_serial_eeprom_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .dev_sel_i(SEL), .sda_oe_o(sda_oe), .busy_o(busy),
        .dbg_addr_i(dbg_addr), .dbg_data_o(dbg_data)
    );

    always @(posedge clk) begin
        if (busy) busy_run <= busy_run + 1;
        else if (busy_run != 0) begin
            last_len <= busy_run;
            busy_run <= 0;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(H);
        scl = 1'b1;   wait_clk(H);
        sda_m = 1'b0; wait_clk(H);
        scl = 1'b0;   wait_clk(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(H);
        scl = 1'b1;   wait_clk(H);
        sda_m = 1'b1; wait_clk(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic early,
                             output logic late, output logic rel);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clk(H);
            scl = 1'b1;   wait_clk(H);
            scl = 1'b0;
        end
        sda_m = 1'b1;
        wait_clk(H/2); early = sda_oe;
        wait_clk(H/2); scl = 1'b1;
        wait_clk(H/2); late = sda_oe;
        wait_clk(H/2); scl = 1'b0;
        wait_clk(H/2); rel = sda_oe;
    endtask

    task automatic sweep(input string req);
        int mism = 0;
        int first = -1;
        for (int a = 0; a < 256; a++) begin
            dbg_addr = 8'(a);
            wait_clk(1);
            if (dbg_data !== model[a]) begin
                mism++;
                if (first < 0) first = a;
            end
        end
        chk(mism == 0, req, first, 0);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 3 * WR_CYC && busy; k++) wait_clk(1);
        wait_clk(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic e, l, r;
        for (int a = 0; a < 256; a++) model[a] = 8'hFF;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);

        // R1 reset state
        chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        dbg_addr = 8'h00; wait_clk(1);
        chk(dbg_data == 8'hFF, "R1 erased memory", dbg_data, 8'hFF);

        // table: R2 R3 R4 R5 R6 R7 R8 R9 R11
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] dev, word, seed;
            logic [4:0] cnt;
            logic exp;
            logic [7:0] tgt;
            {dev, word, cnt, seed, exp} = VEC[v];
            bus_start();
            send_byte(dev, e, l, r);
            chk(e == exp, "R2/R3/R4 ack after bit 8 fall", e, exp);
            chk(l == exp, "R2/R3/R4 ack in ninth high", l, exp);
            chk(r == 1'b0, "R2 ack released", r, 0);
            send_byte(word, e, l, r);
            chk(l == exp, "R5/R3 word address ack", l, exp);
            for (int j = 0; j < cnt; j++) begin
                send_byte(8'(seed + 8'(j)), e, l, r);
                chk(l == exp, "R5/R3 data ack", l, exp);
            end
            bus_stop();
            if (exp && cnt != 0) begin
                chk(busy == 1'b1, "R9 busy after stop", busy, 1);
                dbg_addr = word; wait_clk(1);
                chk(dbg_data == model[word], "R9 old data while busy", dbg_data, model[word]);
                for (int j = 0; j < cnt; j++) begin
                    tgt = {word[7:4], 4'(word[3:0] + 4'(j))};
                    model[tgt] = 8'(seed + 8'(j));
                end
                wait_idle();
                chk(last_len == WR_CYC, "R9 busy length", last_len, WR_CYC);
            end else begin
                wait_clk(20);
                chk(busy == 1'b0, "R11/R3 no write cycle", busy, 0);
            end
            sweep("R6/R7/R8/R3/R4 memory contents");
        end

        // R10 acknowledge polling during the write cycle
        bus_start();
        send_byte(8'hAA, e, l, r);
        send_byte(8'h90, e, l, r);
        send_byte(8'h5A, e, l, r);
        bus_stop();
        model[8'h90] = 8'h5A;
        bus_start();
        send_byte(8'hAA, e, l, r);
        chk(l == 1'b0, "R10 no ack while busy", l, 0);
        send_byte(8'hA0, e, l, r);
        chk(l == 1'b0, "R10 word ignored while busy", l, 0);
        send_byte(8'h55, e, l, r);
        chk(l == 1'b0, "R10 data ignored while busy", l, 0);
        bus_stop();
        chk(busy == 1'b1, "R10 still busy after polling", busy, 1);
        wait_idle();
        chk(last_len == WR_CYC, "R10 timer not restarted", last_len, WR_CYC);
        bus_start();
        send_byte(8'hAA, e, l, r);
        chk(l == 1'b1, "R10 ack once idle", l, 1);
        bus_stop();
        wait_clk(20);
        chk(busy == 1'b0, "R11 address-only stop", busy, 0);
        sweep("R10 memory after polling");

        // R12 repeated start discards buffered bytes
        bus_start();
        send_byte(8'hAA, e, l, r);
        send_byte(8'hB0, e, l, r);
        send_byte(8'h11, e, l, r);
        send_byte(8'h22, e, l, r);
        bus_start();
        send_byte(8'hAA, e, l, r);
        chk(l == 1'b1, "R12 repeated start detected", l, 1);
        bus_stop();
        wait_clk(20);
        chk(busy == 1'b0, "R12 no write after repeated start", busy, 0);
        sweep("R12 memory unchanged");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule